// File: doc/BRIEF.md
# A20 Gate Control Register

This block is a one-byte system control register that sits on a PC-compatible I/O bus at port address 0x92. It holds an alternate address-line-20 gate bit and a fast CPU reset request bit. The gate bit is combined with the keyboard controller's gate input and a CPU reset input to form the A20 mask output for the processor. Either source can force the mask high, and the mask is low only when every term is low.

The I/O side uses plain single-cycle strobes with no back-pressure. A write strobe with a matching address updates the register on that clock edge. A read strobe with a matching address returns the register contents combinationally, in the same cycle, with a qualifying valid flag. The bus never stalls, so no ready signal exists. Writing 1 to bit 0 requests a fast reset. It produces a one-cycle pulse that also feeds the reset term of the mask, and the bit then clears itself.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset the gate bit and the fast reset pulse are 0, so `a20_mask` equals `kbc_a20_gate | cpu_rst_in`.
- R2: A write (`io_wr`=1, `io_addr`=0x92) with data bit 1 = 1 sets the gate bit on that clock edge. From the next cycle `a20_mask` is 1 whatever `kbc_a20_gate` is.
- R3: A write to 0x92 with data bit 1 = 0 clears the gate bit on that clock edge.
- R4: `a20_mask` is the OR of the gate bit, `kbc_a20_gate`, `cpu_rst_in` and `fast_rst_pulse`. It follows the two inputs in the same cycle.
- R5: A write to 0x92 with data bit 0 = 1 drives `fast_rst_pulse` high for exactly the one cycle after that edge, unless another such write follows. Without a new request the bit then reads 0.
- R6: A read (`io_rd`=1, `io_addr`=0x92) sets `io_rvalid` in the same cycle. `io_rdata` bit 1 is then the gate bit, bit 0 is the pulse bit and bits 7:2 are 0.
- R7: A write to any other address leaves the register unchanged. A read at any other address gives `io_rvalid`=0 and `io_rdata`=0.
- R8: With `io_wr`=0 the data and address buses have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not selected |
| io_rvalid | output | 1 | Read data qualifier |
| kbc_a20_gate | input | 1 | Gate from the keyboard controller |
| cpu_rst_in | input | 1 | External CPU reset term |
| a20_mask | output | 1 | A20 mask to the CPU |
| fast_rst_pulse | output | 1 | One-cycle fast reset request |

## Verification
The hardest case to reach is a read of the register in the one cycle when the self-clearing pulse bit is high, together with back-to-back reset requests that must keep the pulse high without a gap. The bench issues a write with bit 0 set and a same-address read in the next cycle. It also issues two requests in consecutive cycles. A pseudo-random phase then mixes strobes, near-miss addresses and toggling external terms. A behavioural model checks every cycle of all of this.

// File: rtl/a20_pkg.sv
package a20_pkg;
  typedef struct packed {
    logic gate;
    logic pulse;
  } sysctl_t;
endpackage

// File: rtl/a20_decode.sv
module a20_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic sel;
  always_comb begin
    sel    = (io_addr == PORT_ADDR);
    wr_hit = io_wr && sel;
    rd_hit = io_rd && sel;
  end
endmodule

// File: rtl/a20_ctrl_reg.sv
module a20_ctrl_reg
  import a20_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GATE_BIT = 1,
  parameter int RST_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  output sysctl_t           state,
  output logic [DATA_W-1:0] rdata
);
  sysctl_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (wr_hit) st_q.gate <= wdata[GATE_BIT];
      st_q.pulse <= wr_hit && wdata[RST_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[GATE_BIT] = st_q.gate;
      rdata[RST_BIT]  = st_q.pulse;
    end
  end

  assign state = st_q;

  // R2
  gate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (st_q.gate == $past(wdata[GATE_BIT])));
  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(st_q.gate));
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.pulse && !(wr_hit && wdata[RST_BIT])) |=> !st_q.pulse);
  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.pulse) |-> $past(wr_hit && wdata[RST_BIT]));
endmodule

// File: rtl/a20_mask_comb.sv
module a20_mask_comb (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic kbc_gate,
  input  logic cpu_rst,
  input  logic fast_rst,
  output logic mask
);
  logic rst_term;
  always_comb begin
    rst_term = cpu_rst | fast_rst;
    mask     = gate | kbc_gate | rst_term;
  end

  // R2
  gate_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> mask);
  // R4
  low_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> (!kbc_gate && !cpu_rst && !fast_rst && !gate));
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import a20_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic              kbc_a20_gate,
  input  logic              cpu_rst_in,
  output logic              a20_mask,
  output logic              fast_rst_pulse
);
  localparam int GATE_BIT = 1;
  localparam int RST_BIT  = 0;

  logic    wr_hit, rd_hit;
  sysctl_t st;

  a20_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit));

  a20_ctrl_reg #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT), .RST_BIT(RST_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .wdata(io_wdata), .state(st), .rdata(io_rdata));

  a20_mask_comb u_mask (
    .clk(clk), .rst_n(rst_n), .gate(st.gate), .kbc_gate(kbc_a20_gate),
    .cpu_rst(cpu_rst_in), .fast_rst(st.pulse), .mask(a20_mask));

  assign io_rvalid      = rd_hit;
  assign fast_rst_pulse = st.pulse;

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[DATA_W-1:2] == '0);
  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rvalid |-> (io_rdata == '0));
endmodule

// File: tb/sim_a20_gate_ctrl.sv
module sim_a20_gate_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        kbc_a20_gate = 0, cpu_rst_in = 0;
  logic        a20_mask, fast_rst_pulse;

  int n_cmp = 0, n_bad = 0;
  int m_gate = 0, m_pulse = 0;
  bit done = 0;

  always #4 clk = ~clk;

  a20_gate_ctrl u0 (.*);

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive on negedge, compare mid-cycle, then advance the model at posedge
  task automatic step(string tag, logic [15:0] a, logic wr, logic rd,
                      logic [7:0] d, logic kg, logic cr);
    int hw, hr;
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
    kbc_a20_gate = kg; cpu_rst_in = cr;
    #1;
    hw = (wr && a == 16'h0092) ? 1 : 0;
    hr = (rd && a == 16'h0092) ? 1 : 0;
    cmp(tag, "a20_mask", a20_mask, m_gate | kg | cr | m_pulse);
    cmp(tag, "fast_rst_pulse", fast_rst_pulse, m_pulse);
    cmp(tag, "io_rvalid", io_rvalid, hr);
    cmp(tag, "io_rdata", io_rdata, hr ? (m_gate * 2 + m_pulse) : 0);
    @(posedge clk);
    if (hw) m_gate = d[1];
    m_pulse = (hw && d[0]) ? 1 : 0;
    @(negedge clk);
  endtask

  initial begin
    int lfsr = 32'h1d2c3b4a;
    @(negedge clk);
    #1;
    // R1 reset state
    cmp("R1", "a20_mask", a20_mask, 0);
    cmp("R1", "fast_rst_pulse", fast_rst_pulse, 0);
    @(negedge clk);
    rst_n = 1;
    step("R1", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R4", 16'h0000, 0, 0, 8'h00, 1, 0);
    step("R4", 16'h0000, 0, 0, 8'h00, 0, 1);
    step("R2", 16'h0092, 1, 0, 8'h02, 0, 0);
    step("R2", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R2", 16'h0000, 0, 0, 8'h00, 1, 0);
    step("R2", 16'h0000, 0, 0, 8'h00, 0, 0);
    step("R7", 16'h0093, 1, 0, 8'h00, 0, 0);
    step("R7", 16'h0093, 0, 1, 8'h00, 0, 0);
    step("R7", 16'h0192, 1, 0, 8'h00, 0, 0);
    step("R8", 16'h0092, 0, 0, 8'h00, 0, 0);
    step("R8", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R3", 16'h0092, 1, 0, 8'h00, 0, 0);
    step("R3", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R5", 16'h0092, 1, 0, 8'h01, 0, 0);
    step("R5", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R5", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R5", 16'h0092, 1, 0, 8'h01, 0, 0);
    step("R5", 16'h0092, 1, 0, 8'h01, 0, 0);
    step("R5", 16'h0092, 0, 0, 8'h00, 0, 0);
    step("R5", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R6", 16'h0092, 1, 0, 8'hFF, 0, 0);
    step("R6", 16'h0092, 0, 1, 8'h00, 0, 0);
    step("R6", 16'h0092, 0, 1, 8'h00, 1, 1);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
      a = lfsr[3] ? 16'h0092 : {8'h00, 4'h9, lfsr[11:8]};
      step("R4", a, lfsr[4], lfsr[5], lfsr[23:16], lfsr[6] & lfsr[7],
           lfsr[12] & lfsr[13] & lfsr[14]);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule